// File: doc/BRIEF.md
# Memory fault syndrome capture unit

This unit sits next to the fetch and load/store path of a small processor core. Each cycle the path may present one fault report, qualified by a valid pulse. A report carries up to three fault kinds (misaligned data, permission violation, translation miss), the access type and the faulting address. The unit picks one kind by fixed priority and encodes a status word with a cause code and a store flag. When the fault is reported, it captures the address and that status word and sends a one-cycle exception request to the exception controller.

Probe lookups that fail are answered with a failure pulse and change no state. A translation fault that arrives while an earlier translation exception is still unacknowledged is a fatal nested fault. The unit flags it with a sticky output. A combinational side path serves the translation front end. It produces the physical page and permissions, either from identity mapping when translation is off or from the matching entry's bases on a hit. It also produces the secure attribute of the access from per-port non-secure configuration bits.

Top module: `fault_syndrome_unit`

## Requirements
- R1: Access type encoding on `flt_acc` and `xl_acc`: 00 fetch, 01 load, 10 store, 11 load. A permission fault gives cause code 17 for a fetch and 16 for a data access, in status bits [4:0].
- R2: A translation miss gives cause code 19 for a fetch and 18 for a data access.
- R3: For permission and miss faults, status bit 10 is 1 exactly when the access is a store. Every status bit not written for the fault is 0.
- R4: A reported fault loads the full faulting address into `ear`. `exc_req` is high for exactly the one cycle after the edge that sampled the fault.
- R5: A misaligned fault writes cause code 1. The syndrome bits are placed in status bits [11:5] only when `syn_valid` is 1; otherwise the status is the bare code.
- R6: When several fault kinds arrive together, misaligned wins over permission, which wins over miss.
- R7: With `xl_enable` low, `xl_paddr` is `xl_vaddr` with the low PAGE_BITS bits cleared, and `xl_prot` is 3'b111 (bit 2 read, bit 1 write, bit 0 execute).
- R8: With `xl_enable` high and a hit, `xl_paddr` is (physical base + virtual page − virtual base) with the offset bits cleared, and `xl_prot` is the entry's permissions. On a miss both are zero.
- R9: `xl_secure` is the inverse of `ns_iport` for fetches and the inverse of `ns_dport` for data accesses.
- R10: A permission or miss fault with `flt_probe` high pulses `probe_fail` for one cycle. It does not change `ear` or `esr` and raises no request. Misaligned faults ignore `flt_probe`.
- R11: A reported translation fault sets an internal pending state, which `exc_ack` clears; misaligned faults do not set it. A non-probe translation fault while pending sets `recursive_fault` until reset, leaves `ear` and `esr` unchanged and raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flt_valid | input | 1 | Fault report valid this cycle |
| flt_unaligned | input | 1 | Misaligned data fault |
| flt_prot | input | 1 | Permission violation |
| flt_miss | input | 1 | Translation miss |
| flt_acc | input | 2 | Access type of the fault |
| flt_addr | input | ADDR_W | Faulting address |
| flt_probe | input | 1 | Lookup is a probe only |
| syn_valid | input | 1 | Syndrome bits are valid |
| syn_bits | input | SYN_W | Instruction syndrome bits |
| exc_ack | input | 1 | Exception controller acknowledges the translation exception |
| ear | output | ADDR_W | Captured fault address |
| esr | output | STAT_W | Captured status word |
| exc_req | output | 1 | One-cycle exception request |
| probe_fail | output | 1 | One-cycle probe failure pulse |
| recursive_fault | output | 1 | Sticky nested translation fault flag |
| xl_enable | input | 1 | Translation enabled |
| xl_vaddr | input | ADDR_W | Virtual address being translated |
| xl_acc | input | 2 | Access type being translated |
| xl_hit | input | 1 | Lookup found an entry |
| xl_ent_vbase | input | ADDR_W | Entry virtual base |
| xl_ent_pbase | input | ADDR_W | Entry physical base |
| xl_ent_prot | input | 3 | Entry permissions |
| ns_iport | input | 1 | Instruction port non-secure configuration |
| ns_dport | input | 1 | Data port non-secure configuration |
| xl_paddr | output | ADDR_W | Physical page address |
| xl_prot | output | 3 | Permissions granted |
| xl_secure | output | 1 | Secure attribute of the access |

## Verification
The nested-fault condition is the hardest state to reach from the ports. The pending state it depends on is invisible and can only be inferred from whether a later fault is accepted. The stimulus therefore reports a translation fault, withholds the acknowledge and presents a second one. It also shows that a misaligned fault leaves nothing pending by following one directly with a translation fault. Probe misses are placed between real faults so that an unchanged `ear` and `esr` proves nothing was written.

// File: rtl/fsu_pkg.sv
// Package: shared constants and types of the fault syndrome unit.
// Assumes: cause codes fit in CAUSE_W bits of the status word.
package fsu_pkg;
    localparam int CAUSE_W   = 5;
    localparam int STORE_BIT = 10;

    localparam logic [CAUSE_W-1:0] CODE_UNALIGNED = 5'd1;
    localparam logic [CAUSE_W-1:0] CODE_PROT_DATA = 5'd16;
    localparam logic [CAUSE_W-1:0] CODE_PROT_INST = 5'd17;
    localparam logic [CAUSE_W-1:0] CODE_MISS_DATA = 5'd18;
    localparam logic [CAUSE_W-1:0] CODE_MISS_INST = 5'd19;

    localparam logic [1:0] ACC_FETCH = 2'b00;
    localparam logic [1:0] ACC_STORE = 2'b10;

    typedef enum logic [1:0] {
        FK_NONE  = 2'd0,
        FK_UNAL  = 2'd1,
        FK_PROT  = 2'd2,
        FK_MISS  = 2'd3
    } fault_kind_e;
endpackage

// File: rtl/fsu_classify.sv
// Module: picks the winning fault kind and builds the status word.
// Assumes: STAT_W > STORE_BIT and SYN_LSB >= CAUSE_W; purely combinational.
module fsu_classify
    import fsu_pkg::*;
#(
    parameter int SYN_W   = 7,
    parameter int SYN_LSB = 5,
    parameter int STAT_W  = SYN_LSB + SYN_W
) (
    input  logic              unal,
    input  logic              prot,
    input  logic              miss,
    input  logic [1:0]        acc,
    input  logic              syn_valid,
    input  logic [SYN_W-1:0]  syn_bits,
    output fault_kind_e       kind,
    output logic [STAT_W-1:0] status
);
    logic is_fetch;
    logic is_store;

    assign is_fetch = (acc == ACC_FETCH);
    assign is_store = (acc == ACC_STORE);

    // Fixed priority: misaligned, then permission, then miss.
    always_comb begin
        if (unal)      kind = FK_UNAL;
        else if (prot) kind = FK_PROT;
        else if (miss) kind = FK_MISS;
        else           kind = FK_NONE;
    end

    // Status word assembly; unwritten bits stay zero.
    always_comb begin
        status = '0;
        case (kind)
            FK_UNAL: begin
                status[CAUSE_W-1:0] = CODE_UNALIGNED;
                if (syn_valid) status[SYN_LSB +: SYN_W] = syn_bits;
            end
            FK_PROT: begin
                status[CAUSE_W-1:0] = is_fetch ? CODE_PROT_INST : CODE_PROT_DATA;
                status[STORE_BIT]   = is_store;
            end
            FK_MISS: begin
                status[CAUSE_W-1:0] = is_fetch ? CODE_MISS_INST : CODE_MISS_DATA;
                status[STORE_BIT]   = is_store;
            end
            default: status = '0;
        endcase
    end
endmodule

// File: rtl/fsu_xlate.sv
// Module: physical page, permission and secure attribute for one access.
// Assumes: PAGE_BITS < ADDR_W; bases are page aligned or their offsets are ignored.
module fsu_xlate
    import fsu_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12
) (
    input  logic              enable,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [1:0]        acc,
    input  logic              hit,
    input  logic [ADDR_W-1:0] ent_vbase,
    input  logic [ADDR_W-1:0] ent_pbase,
    input  logic [2:0]        ent_prot,
    input  logic              ns_i,
    input  logic              ns_d,
    output logic [ADDR_W-1:0] paddr,
    output logic [2:0]        prot,
    output logic              secure
);
    localparam logic [ADDR_W-1:0] PG_MASK =
        {{(ADDR_W-PAGE_BITS){1'b1}}, {PAGE_BITS{1'b0}}};

    logic [ADDR_W-1:0] vpage;
    logic [ADDR_W-1:0] mapped;

    assign vpage  = vaddr & PG_MASK;
    assign mapped = ent_pbase + vpage - ent_vbase;

    // Select identity, mapped or empty translation.
    always_comb begin
        if (!enable) begin
            paddr = vpage;
            prot  = 3'b111;
        end else if (hit) begin
            paddr = mapped & PG_MASK;
            prot  = ent_prot;
        end else begin
            paddr = '0;
            prot  = 3'b000;
        end
    end

    // Secure attribute from the port that carries the access.
    always_comb begin
        secure = (acc == ACC_FETCH) ? !ns_i : !ns_d;
    end
endmodule

// File: rtl/fsu_capture.sv
// Module: address/status capture, request pulse, probe and nested-fault handling.
// Assumes: kind and status come from fsu_classify in the same cycle as valid.
module fsu_capture
    import fsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STAT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  fault_kind_e       kind,
    input  logic [STAT_W-1:0] status,
    input  logic [ADDR_W-1:0] addr,
    input  logic              probe,
    input  logic              ack,
    output logic [ADDR_W-1:0] ear_q,
    output logic [STAT_W-1:0] esr_q,
    output logic              req_q,
    output logic              pfail_q,
    output logic              rec_q
);
    logic pend_q;
    logic is_tr;

    assign is_tr = (kind == FK_PROT) || (kind == FK_MISS);

    // Capture registers and one-cycle pulses; a new fault's pending set wins over ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ear_q   <= '0;
            esr_q   <= '0;
            req_q   <= 1'b0;
            pfail_q <= 1'b0;
            rec_q   <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            req_q   <= 1'b0;
            pfail_q <= 1'b0;
            if (ack) pend_q <= 1'b0;
            if (valid && kind == FK_UNAL) begin
                ear_q <= addr;
                esr_q <= status;
                req_q <= 1'b1;
            end else if (valid && is_tr) begin
                if (probe) begin
                    pfail_q <= 1'b1;
                end else if (pend_q) begin
                    rec_q <= 1'b1;
                end else begin
                    ear_q  <= addr;
                    esr_q  <= status;
                    req_q  <= 1'b1;
                    pend_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/fault_syndrome_unit.sv
// Module: top of the memory fault syndrome capture unit.
// Assumes: one fault report per valid pulse; translation side path is combinational.
module fault_syndrome_unit
    import fsu_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int SYN_W     = 7,
    parameter int SYN_LSB   = 5,
    parameter int STAT_W    = SYN_LSB + SYN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flt_valid,
    input  logic              flt_unaligned,
    input  logic              flt_prot,
    input  logic              flt_miss,
    input  logic [1:0]        flt_acc,
    input  logic [ADDR_W-1:0] flt_addr,
    input  logic              flt_probe,
    input  logic              syn_valid,
    input  logic [SYN_W-1:0]  syn_bits,
    input  logic              exc_ack,
    output logic [ADDR_W-1:0] ear,
    output logic [STAT_W-1:0] esr,
    output logic              exc_req,
    output logic              probe_fail,
    output logic              recursive_fault,
    input  logic              xl_enable,
    input  logic [ADDR_W-1:0] xl_vaddr,
    input  logic [1:0]        xl_acc,
    input  logic              xl_hit,
    input  logic [ADDR_W-1:0] xl_ent_vbase,
    input  logic [ADDR_W-1:0] xl_ent_pbase,
    input  logic [2:0]        xl_ent_prot,
    input  logic              ns_iport,
    input  logic              ns_dport,
    output logic [ADDR_W-1:0] xl_paddr,
    output logic [2:0]        xl_prot,
    output logic              xl_secure
);
    fault_kind_e       kind;
    logic [STAT_W-1:0] status;

    fsu_classify #(.SYN_W(SYN_W), .SYN_LSB(SYN_LSB), .STAT_W(STAT_W)) u_cls (
        .unal      (flt_unaligned),
        .prot      (flt_prot),
        .miss      (flt_miss),
        .acc       (flt_acc),
        .syn_valid (syn_valid),
        .syn_bits  (syn_bits),
        .kind      (kind),
        .status    (status)
    );

    fsu_capture #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (flt_valid),
        .kind    (kind),
        .status  (status),
        .addr    (flt_addr),
        .probe   (flt_probe),
        .ack     (exc_ack),
        .ear_q   (ear),
        .esr_q   (esr),
        .req_q   (exc_req),
        .pfail_q (probe_fail),
        .rec_q   (recursive_fault)
    );

    fsu_xlate #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_xl (
        .enable    (xl_enable),
        .vaddr     (xl_vaddr),
        .acc       (xl_acc),
        .hit       (xl_hit),
        .ent_vbase (xl_ent_vbase),
        .ent_pbase (xl_ent_pbase),
        .ent_prot  (xl_ent_prot),
        .ns_i      (ns_iport),
        .ns_d      (ns_dport),
        .paddr     (xl_paddr),
        .prot      (xl_prot),
        .secure    (xl_secure)
    );
endmodule

// File: rtl/fsu_checker.sv
// Module: temporal checks on the fault syndrome unit, attached by bind.
// Assumes: default parameters keep STAT_W above bit 10.
module fsu_checker #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int SYN_W     = 7,
    parameter int STAT_W    = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flt_valid,
    input logic              flt_unaligned,
    input logic              flt_prot,
    input logic              flt_miss,
    input logic [1:0]        flt_acc,
    input logic [ADDR_W-1:0] flt_addr,
    input logic              exc_req,
    input logic              probe_fail,
    input logic              recursive_fault,
    input logic [ADDR_W-1:0] ear,
    input logic [STAT_W-1:0] esr,
    input logic              xl_enable,
    input logic [ADDR_W-1:0] xl_vaddr,
    input logic [1:0]        xl_acc,
    input logic [ADDR_W-1:0] xl_paddr,
    input logic [2:0]        xl_prot,
    input logic              xl_secure,
    input logic              ns_iport
);
    p_req_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> $past(flt_valid));

    p_ear_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req |-> ear == $past(flt_addr));

    p_prot_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && $past(flt_prot && !flt_unaligned)) |->
        esr[4:0] == (($past(flt_acc) == 2'b00) ? 5'd17 : 5'd16));

    p_miss_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && $past(flt_miss && !flt_prot && !flt_unaligned)) |->
        esr[4:0] == (($past(flt_acc) == 2'b00) ? 5'd19 : 5'd18));

    p_store_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req && $past(!flt_unaligned)) |-> esr[10] == ($past(flt_acc) == 2'b10));

    p_probe_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        probe_fail |-> (!exc_req && $stable(ear) && $stable(esr)));

    p_rec_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        recursive_fault |=> recursive_fault);

    p_identity_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_enable |-> (xl_prot == 3'b111 && xl_paddr[PAGE_BITS-1:0] == '0 &&
                        xl_paddr[ADDR_W-1:PAGE_BITS] == xl_vaddr[ADDR_W-1:PAGE_BITS]));

    p_secure_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_acc == 2'b00) |-> (xl_secure != ns_iport));
endmodule

bind fault_syndrome_unit fsu_checker #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .SYN_W(SYN_W), .STAT_W(STAT_W)
) u_chk (.*);

// File: tb/sim_fault_syndrome_unit.sv
module sim_fault_syndrome_unit;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int SW = 7;
    localparam int TW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flt_valid = 0, flt_unaligned = 0, flt_prot = 0, flt_miss = 0;
    logic [1:0] flt_acc = 0;
    logic [AW-1:0] flt_addr = 0;
    logic flt_probe = 0, syn_valid = 0;
    logic [SW-1:0] syn_bits = 0;
    logic exc_ack = 0;
    logic [AW-1:0] ear;
    logic [TW-1:0] esr;
    logic exc_req, probe_fail, recursive_fault;
    logic xl_enable = 0;
    logic [AW-1:0] xl_vaddr = 0;
    logic [1:0] xl_acc = 0;
    logic xl_hit = 0;
    logic [AW-1:0] xl_ent_vbase = 0, xl_ent_pbase = 0;
    logic [2:0] xl_ent_prot = 0;
    logic ns_iport = 0, ns_dport = 0;
    logic [AW-1:0] xl_paddr;
    logic [2:0] xl_prot;
    logic xl_secure;

    fault_syndrome_unit u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [AW-1:0] ear;
        logic [TW-1:0] esr;
        logic req;
        logic pf;
        logic rec;
        int due;
        string tag;
    } item_t;

    item_t q[$];
    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    logic [AW-1:0] m_ear = 0;
    logic [TW-1:0] m_esr = 0;
    logic m_pend = 0, m_rec = 0;

    always @(posedge clk) cyc++;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Monitor: compares design outputs against items due this cycle.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due == cyc) begin
            item_t it;
            it = q.pop_front();
            chk({it.tag, " R4 ear"}, 64'(ear), 64'(it.ear));
            chk({it.tag, " esr"}, 64'(esr), 64'(it.esr));
            chk({it.tag, " R4 exc_req"}, 64'(exc_req), 64'(it.req));
            chk({it.tag, " R10 probe_fail"}, 64'(probe_fail), 64'(it.pf));
            chk({it.tag, " R11 recursive"}, 64'(recursive_fault), 64'(it.rec));
        end
    end

    function automatic logic [TW-1:0] model_esr(input logic u, input logic p, input logic m,
                                                 input logic [1:0] acc, input logic sv,
                                                 input logic [SW-1:0] sb);
        logic [TW-1:0] r;
        r = '0;
        if (u) begin
            r = 12'd1;
            if (sv) r = r | (TW'(sb) << 5);
        end else if (p || m) begin
            r = p ? ((acc == 2'b00) ? 12'd17 : 12'd16) : ((acc == 2'b00) ? 12'd19 : 12'd18);
            if (acc == 2'b10) r = r | 12'h400;
        end
        return r;
    endfunction

    // Driver: applies one fault report and pushes the expected outcome.
    task automatic fault(input string tag, input logic u, input logic p, input logic m,
                         input logic [1:0] acc, input logic [AW-1:0] addr, input logic probe,
                         input logic sv, input logic [SW-1:0] sb);
        item_t it;
        flt_valid = 1; flt_unaligned = u; flt_prot = p; flt_miss = m;
        flt_acc = acc; flt_addr = addr; flt_probe = probe; syn_valid = sv; syn_bits = sb;
        it.req = 0; it.pf = 0;
        if (u) begin
            m_ear = addr; m_esr = model_esr(u, p, m, acc, sv, sb); it.req = 1;
        end else if (p || m) begin
            if (probe) it.pf = 1;
            else if (m_pend) m_rec = 1;
            else begin
                m_ear = addr; m_esr = model_esr(u, p, m, acc, sv, sb);
                it.req = 1; m_pend = 1;
            end
        end
        it.ear = m_ear; it.esr = m_esr; it.rec = m_rec; it.due = cyc + 1; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
        flt_valid = 0; flt_unaligned = 0; flt_prot = 0; flt_miss = 0; flt_probe = 0;
    endtask

    // Acknowledge: clears pending and checks the request has dropped.
    task automatic ack(input string tag);
        item_t it;
        exc_ack = 1;
        m_pend = 0;
        it.ear = m_ear; it.esr = m_esr; it.req = 0; it.pf = 0; it.rec = m_rec;
        it.due = cyc + 1; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
        exc_ack = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("reset R4 exc_req", 64'(exc_req), 0);
        chk("reset ear/esr R3", 64'({ear, esr}), 0);
        chk("reset R11 recursive", 64'(recursive_fault), 0);

        fault("R1 prot fetch", 0, 1, 0, 2'b00, 32'h1000_0ABC, 0, 0, 0);
        ack("R4 req drop");
        fault("R1 prot load", 0, 1, 0, 2'b01, 32'h2000_0004, 0, 0, 0);
        ack("ack");
        fault("R3 prot store", 0, 1, 0, 2'b10, 32'h2000_0008, 0, 0, 0);
        ack("ack");
        fault("R2 miss load", 0, 0, 1, 2'b01, 32'h3000_0010, 0, 0, 0);
        ack("ack");
        fault("R2 miss fetch", 0, 0, 1, 2'b00, 32'h3000_0020, 0, 0, 0);
        ack("ack");
        fault("R3 miss store", 0, 0, 1, 2'b10, 32'hFFFF_FFFC, 0, 0, 0);
        ack("ack");
        fault("R3 miss acc11", 0, 0, 1, 2'b11, 32'h0000_0040, 0, 1, 7'h7F);
        ack("ack");
        fault("R5 unal syn", 1, 0, 0, 2'b01, 32'h0000_0101, 0, 1, 7'h55);
        fault("R5 unal nosyn", 1, 0, 0, 2'b10, 32'h0000_0203, 0, 0, 7'h7F);
        fault("R11 unal no pend", 0, 1, 0, 2'b00, 32'h0000_0300, 0, 0, 0);
        ack("ack");
        fault("R6 all three", 1, 1, 1, 2'b10, 32'h0000_0405, 0, 0, 0);
        fault("R6 prot over miss", 0, 1, 1, 2'b00, 32'h0000_0500, 0, 0, 0);
        ack("ack");
        fault("R10 probe miss", 0, 0, 1, 2'b01, 32'hDEAD_0000, 1, 0, 0);
        fault("R10 probe prot", 0, 1, 0, 2'b10, 32'hBEEF_0000, 1, 0, 0);
        fault("R10 unal probe", 1, 0, 0, 2'b01, 32'h0000_0607, 1, 1, 7'h01);
        fault("R11 first", 0, 1, 0, 2'b01, 32'h0000_0700, 0, 0, 0);
        fault("R11 nested", 0, 0, 1, 2'b01, 32'h0000_0800, 0, 0, 0);
        ack("R11 after ack");
        fault("R11 still sticky", 0, 0, 1, 2'b00, 32'h0000_0900, 0, 0, 0);
        ack("ack");

        xl_enable = 0; xl_vaddr = 32'h1234_5678; #1;
        chk("R7 identity paddr", 64'(xl_paddr), 64'h1234_5000);
        chk("R7 identity prot", 64'(xl_prot), 64'h7);
        xl_enable = 1; xl_hit = 1; xl_ent_vbase = 32'h4000_0000; xl_ent_pbase = 32'h8000_0000;
        xl_ent_prot = 3'b101; xl_vaddr = 32'h4000_3ABC; #1;
        chk("R8 hit paddr", 64'(xl_paddr), 64'h8000_3000);
        chk("R8 hit prot", 64'(xl_prot), 64'h5);
        xl_hit = 0; #1;
        chk("R8 miss paddr/prot", 64'({xl_paddr, xl_prot}), 0);
        ns_iport = 1; ns_dport = 0; xl_acc = 2'b00; #1;
        chk("R9 fetch nonsecure", 64'(xl_secure), 0);
        xl_acc = 2'b01; #1;
        chk("R9 load secure", 64'(xl_secure), 1);
        ns_dport = 1; xl_acc = 2'b10; #1;
        chk("R9 store nonsecure", 64'(xl_secure), 0);

        repeat (3) @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule